// File: doc/BRIEF.md
# OTP Fuse Array Controller

This block fronts a simulated one-time-programmable fuse array. The array holds eight user rows, a control word of lock and policy fuses, a word for a multi-bit signature-required policy group, a 256-bit write-only secret key and two 384-bit public-key hash fields. A host programs fuses through a small register bus. Each write ORs its data into the addressed word, so a fuse can go from 0 to 1 but never back. Per-row and per-field lock fuses refuse any further programming.

All reads come from a register cache, never from the array. The cache is refreshed only by an explicit load command. The secret key is never returned on the read path. Its integrity is checked instead by running a CRC-32 over the cached key and comparing the result with a value the host supplies. Redundant policy groups in the cache are reduced to single enables, and each enable is set when any bit of its group is set. While the cache has not yet been loaded, every enable is held at its most restrictive value. The simulated array starts blank at reset.

Word map (6-bit word address): 0..7 user rows, 8 control word, 9 signature group, 16..23 key (least significant word at 16), 24..35 hash field A, 36..47 hash field B (a 256-bit hash sits in the lowest eight words of its field). All other addresses are unmapped.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: `rdata_o` returns the cached copy of the addressed word. A write shows in the read data only after a later cache load completes. Reads of key addresses 16..23, of unmapped addresses and of any address before the first load return 0.
- R2: A write to an unlocked mapped word sets array word = old | `wdata_i`. No fuse bit ever returns to 0.
- R3: Control bit n (n = 0..7) locks user row n. A write to a locked row leaves the array unchanged and sets `err_o`, which stays high until reset. Writes to unmapped addresses have no effect and do not set `err_o`.
- R4: Control bit 9 locks the key words, bit 10 locks hash field A and bit 11 locks hash field B. A locked field behaves like a locked row in R3. A lock takes effect on the next write after the lock fuse is programmed, without a cache load.
- R5: A load command raises `busy_o` for exactly LOAD_CYC cycles (default 4). In the next cycle `done_o` pulses for one cycle with `pass_o` = 1, and the cache then holds the array.
- R6: After reset, `busy_o`, `done_o`, `pass_o` and `err_o` are 0, the cache reads as zero, and all five policy enables are 1.
- R7: A key check with the key check enabled raises `busy_o` for 8 cycles. It then pulses `done_o`, with `pass_o` = 1 exactly when the CRC of the cached key equals `wdata_i` as sampled with the command. The CRC uses polynomial 0x04C11DB7 and initial value 0xFFFFFFFF, with no reflection and no final XOR. It shifts in each word MSB first, starting with the least significant key word.
- R8: If the cache is not yet valid, or cached control bit 8 (key-check disable) is set, a key-check command pulses `done_o` one cycle later with `pass_o` = 0 and without raising `busy_o`.
- R9: Each policy enable is the OR of its cached group: `scrub_en_o` of control bits 14:12, `halt_on_err_o` of bits 17:15, `revoke_a_o` of bits 19:18, `revoke_b_o` of bits 21:20, and `sig_req_o` of bits 14:0 of word 9.
- R10: Commands that arrive while `busy_o` is high are ignored. When a load and a key check arrive in the same idle cycle, the load is carried out and the key check is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 6 | Word address for reads and programming |
| wdata_i | input | 32 | Programming data; expected CRC with a key-check command |
| we_i | input | 1 | Program strobe |
| rdata_o | output | 32 | Cached word at `addr_i` |
| load_i | input | 1 | Cache load command |
| crc_i | input | 1 | Key CRC check command |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result of the last operation |
| err_o | output | 1 | Sticky locked-write error |
| scrub_en_o | output | 1 | Register scrub policy enable |
| halt_on_err_o | output | 1 | Halt-on-error policy enable |
| revoke_a_o | output | 1 | Hash field A revoked |
| revoke_b_o | output | 1 | Hash field B revoked |
| sig_req_o | output | 1 | Signature-required policy enable |

## Verification
The assertions check on every cycle the properties that need no model of the data:
- fuse bits never clear;
- the cache changes only on a successful load completion;
- `done_o` is a single-cycle pulse that never overlaps `busy_o`;
- a write to a locked row or locked key field raises the error flag and leaves the array unchanged;
- the policy enables stay restrictive while the cache is invalid.

Only the bench scenarios can show the rest:
- the exact busy lengths;
- the visibility of writes after a reload;
- the CRC value and its pass or fail result;
- the key-check disable;
- the priority and dropping of overlapping commands;
- the OR decoding of each policy group against a random fuse history.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned N_USER     = 8;
  localparam int unsigned KEY_WORDS  = 8;
  localparam int unsigned HASH_WORDS = 12;
  localparam int unsigned KEY_OFS    = 16;
  localparam int unsigned N_WORDS    = KEY_OFS + KEY_WORDS + 2 * HASH_WORDS;
  localparam int unsigned ADDR_W     = $clog2(N_WORDS);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] image_t;

  localparam addr_t CTL_ADDR   = addr_t'(N_USER);
  localparam addr_t SIG_ADDR   = addr_t'(N_USER + 1);
  localparam addr_t KEY_BASE   = addr_t'(KEY_OFS);
  localparam addr_t HASHA_BASE = addr_t'(KEY_OFS + KEY_WORDS);
  localparam addr_t HASHB_BASE = addr_t'(KEY_OFS + KEY_WORDS + HASH_WORDS);

  // control word bit positions
  localparam int unsigned KEY_RDIS_BIT  = 8;
  localparam int unsigned KEY_WLOCK_BIT = 9;
  localparam int unsigned HA_WLOCK_BIT  = 10;
  localparam int unsigned HB_WLOCK_BIT  = 11;
  localparam int unsigned POL_LSB       = 12;
  localparam int unsigned POL_CTL_W     = 10;
  localparam int unsigned SIG_W         = 15;
  localparam int unsigned POL_W         = POL_CTL_W + SIG_W;
  localparam int unsigned N_POL         = 5;

  localparam word_t CRC_POLY = 32'h04C1_1DB7;
  localparam word_t CRC_INIT = 32'hFFFF_FFFF;

  function automatic logic in_range(addr_t a, addr_t base, int unsigned n);
    return (a >= base) && (a < base + addr_t'(n));
  endfunction

  function automatic word_t crc_step(word_t c, word_t d);
    word_t r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (r[WORD_W-1] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else                    r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  addr_t  addr_i,
  input  word_t  wdata_i,
  output image_t arr_o,
  output logic   err_o
);
  localparam int unsigned ROW_W = $clog2(N_USER);

  image_t arr_q;
  logic   err_q;
  logic   mapped, locked;

  always_comb begin
    mapped = 1'b0;
    locked = 1'b0;
    if (addr_i < addr_t'(N_USER)) begin
      mapped = 1'b1;
      locked = arr_q[CTL_ADDR][addr_i[ROW_W-1:0]];
    end else if (addr_i == CTL_ADDR || addr_i == SIG_ADDR) begin
      mapped = 1'b1;
    end else if (in_range(addr_i, KEY_BASE, KEY_WORDS)) begin
      mapped = 1'b1;
      locked = arr_q[CTL_ADDR][KEY_WLOCK_BIT];
    end else if (in_range(addr_i, HASHA_BASE, HASH_WORDS)) begin
      mapped = 1'b1;
      locked = arr_q[CTL_ADDR][HA_WLOCK_BIT];
    end else if (in_range(addr_i, HASHB_BASE, HASH_WORDS)) begin
      mapped = 1'b1;
      locked = arr_q[CTL_ADDR][HB_WLOCK_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_q <= '0;
      err_q <= 1'b0;
    end else if (we_i && mapped) begin
      if (locked) err_q <= 1'b1;
      else        arr_q[addr_i] <= arr_q[addr_i] | wdata_i;
    end
  end

  assign arr_o = arr_q;
  assign err_o = err_q;
endmodule

// File: rtl/otp_cache_seq.sv
module otp_cache_seq
  import otp_pkg::*;
#(
  parameter int unsigned LOAD_CYC = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  logic   crc_i,
  input  word_t  crc_ref_i,
  input  image_t arr_i,
  output image_t cache_o,
  output logic   vld_o,
  output logic   busy_o,
  output logic   done_o,
  output logic   pass_o
);
  localparam int unsigned MAX_CYC = (LOAD_CYC > KEY_WORDS) ? LOAD_CYC : KEY_WORDS;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC) + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_CRC} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  image_t           cache_q;
  logic             vld_q, done_q, pass_q;
  word_t            crc_q, ref_q, crc_nxt;

  assign crc_nxt = crc_step(crc_q, cache_q[KEY_BASE + addr_t'(cnt_q)]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      cache_q <= '0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      crc_q   <= CRC_INIT;
      ref_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (load_i) begin
            st_q   <= S_LOAD;
            pass_q <= 1'b0;
          end else if (crc_i) begin
            pass_q <= 1'b0;
            if (!vld_q || cache_q[CTL_ADDR][KEY_RDIS_BIT]) begin
              done_q <= 1'b1;  // check disabled: immediate fail
            end else begin
              st_q  <= S_CRC;
              crc_q <= CRC_INIT;
              ref_q <= crc_ref_i;
            end
          end
        end
        S_LOAD: begin
          if (cnt_q == CNT_W'(LOAD_CYC - 1)) begin
            st_q    <= S_IDLE;
            cache_q <= arr_i;
            vld_q   <= 1'b1;
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_CRC: begin
          crc_q <= crc_nxt;
          if (cnt_q == CNT_W'(KEY_WORDS - 1)) begin
            st_q   <= S_IDLE;
            done_q <= 1'b1;
            pass_q <= (crc_nxt == ref_q);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cache_o = cache_q;
  assign vld_o   = vld_q;
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;
  assign pass_o  = pass_q;
endmodule

// File: rtl/otp_policy.sv
module otp_policy
  import otp_pkg::*;
(
  input  logic             vld_i,
  input  logic [POL_W-1:0] pol_bits_i,
  output logic [N_POL-1:0] en_o
);
  // group layout inside pol_bits_i: scrub, halt, revoke A, revoke B, signature
  localparam int unsigned G_LSB [N_POL] = '{0, 3, 6, 8, 10};
  localparam int unsigned G_W   [N_POL] = '{3, 3, 2, 2, SIG_W};

  for (genvar g = 0; g < N_POL; g++) begin : g_grp
    assign en_o[g] = !vld_i || (|pol_bits_i[G_LSB[g] +: G_W[g]]);
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned LOAD_CYC = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic                we_i,
  output logic [WORD_W-1:0]   rdata_o,
  input  logic                load_i,
  input  logic                crc_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o,
  output logic                err_o,
  output logic                scrub_en_o,
  output logic                halt_on_err_o,
  output logic                revoke_a_o,
  output logic                revoke_b_o,
  output logic                sig_req_o
);
  image_t           arr, cache;
  logic             cache_vld;
  logic [POL_W-1:0] pol_bits;
  logic [N_POL-1:0] pol_en;

  otp_fuse_array i_array (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .arr_o (arr),
    .err_o (err_o)
  );

  otp_cache_seq #(.LOAD_CYC(LOAD_CYC)) i_seq (
    .clk_i, .rst_ni, .load_i, .crc_i,
    .crc_ref_i (wdata_i),
    .arr_i     (arr),
    .cache_o   (cache),
    .vld_o     (cache_vld),
    .busy_o, .done_o, .pass_o
  );

  assign pol_bits = {cache[SIG_ADDR][SIG_W-1:0], cache[CTL_ADDR][POL_LSB +: POL_CTL_W]};

  otp_policy i_policy (
    .vld_i      (cache_vld),
    .pol_bits_i (pol_bits),
    .en_o       (pol_en)
  );

  assign {sig_req_o, revoke_b_o, revoke_a_o, halt_on_err_o, scrub_en_o} = pol_en;

  always_comb begin
    if (in_range(addr_i, KEY_BASE, KEY_WORDS) || addr_i >= addr_t'(N_WORDS)) rdata_o = '0;
    else rdata_o = cache[addr_i];
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
  import otp_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   we_i,
  input addr_t  addr_i,
  input image_t arr_i,
  input image_t cache_i,
  input logic   vld_i,
  input logic   busy_o,
  input logic   done_o,
  input logic   pass_o,
  input logic   err_o,
  input logic   scrub_en_o,
  input logic   halt_on_err_o,
  input logic   revoke_a_o,
  input logic   revoke_b_o,
  input logic   sig_req_o
);
  localparam int unsigned ROW_W = $clog2(N_USER);

  a_r2_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((arr_i & $past(arr_i)) == $past(arr_i)));

  a_r1_cache_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cache_i) |-> (done_o && pass_o));

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r3_row_lock_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i < addr_t'(N_USER) && arr_i[CTL_ADDR][addr_i[ROW_W-1:0]]) |=> err_o);

  a_r4_key_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && in_range(addr_i, KEY_BASE, KEY_WORDS) && arr_i[CTL_ADDR][KEY_WLOCK_BIT])
      |=> (err_o && arr_i == $past(arr_i)));

  a_r6_invalid_restrictive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |-> (scrub_en_o && halt_on_err_o && revoke_a_o && revoke_b_o && sig_req_o));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk i_chk (
  .clk_i, .rst_ni, .we_i, .addr_i,
  .arr_i (arr), .cache_i (cache), .vld_i (cache_vld),
  .busy_o, .done_o, .pass_o, .err_o,
  .scrub_en_o, .halt_on_err_o, .revoke_a_o, .revoke_b_o, .sig_req_o
);

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;
  localparam time CLK_P    = 10ns;
  localparam int  LOAD_CYC = 4;
  localparam int  NW       = 48;

  logic        clk = 0, rst_ni = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        we = 0, load = 0, crc = 0;
  logic        busy, done, pass, err, scrub, halt, rva, rvb, sig;

  otp_fuse_ctrl #(.LOAD_CYC(LOAD_CYC)) i_otp_fuse_ctrl (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata),
    .load_i(load), .crc_i(crc), .busy_o(busy), .done_o(done), .pass_o(pass), .err_o(err),
    .scrub_en_o(scrub), .halt_on_err_o(halt), .revoke_a_o(rva), .revoke_b_o(rvb),
    .sig_req_o(sig)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] m_arr [NW];
  logic [31:0] m_cache [NW];
  bit m_vld = 0, m_err = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit m_mapped(int a);
    return a < 10 || (a >= 16 && a < NW);
  endfunction

  function automatic bit m_locked(int a);
    if (a < 8)  return m_arr[8][a];
    if (a >= 16 && a < 24) return m_arr[8][9];
    if (a >= 24 && a < 36) return m_arr[8][10];
    if (a >= 36 && a < 48) return m_arr[8][11];
    return 0;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if ((a >= 16 && a < 24) || a >= NW) return 32'h0;
    return m_cache[a];
  endfunction

  function automatic logic [4:0] m_pol();
    logic [31:0] c = m_cache[8];
    if (!m_vld) return 5'h1f;
    return {|m_cache[9][14:0], |c[21:20], |c[19:18], |c[17:15], |c[14:12]};
  endfunction

  // CRC-32, MSB-first bit serial over the key, least significant word first
  function automatic logic [31:0] m_crc();
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [255:0] k;
    for (int w = 0; w < 8; w++) k[w*32 +: 32] = m_cache[16 + w];
    for (int w = 0; w < 8; w++)
      for (int b = 31; b >= 0; b--) begin
        logic fb = c[31] ^ k[w*32 + b];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); we = 1; addr = 6'(a); wdata = d;
    @(negedge clk); we = 0;
    if (m_mapped(a)) begin
      if (m_locked(a)) m_err = 1;
      else m_arr[a] = m_arr[a] | d;
    end
    chk(m_locked(a) ? "R3/R4 err set" : "R3 err", {31'b0, err}, {31'b0, m_err});
  endtask

  task automatic rd_chk(int a, string req);
    @(negedge clk); addr = 6'(a); #1;
    chk(req, rdata, m_read(a));
  endtask

  task automatic chk_pol(string req);
    chk(req, {27'b0, sig, rvb, rva, halt, scrub}, {27'b0, m_pol()});
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 64) begin n++; @(negedge clk); end
  endtask

  task automatic do_load();
    int n;
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
    wait_idle(n);
    chk("R5 load busy cycles", n, LOAD_CYC);
    chk("R5 load done/pass", {30'b0, done, pass}, 32'h3);
    for (int i = 0; i < NW; i++) m_cache[i] = m_arr[i];
    m_vld = 1;
    chk_pol("R9 policy after load");
  endtask

  task automatic do_crc(logic [31:0] ref_v);
    int n;
    bit en = m_vld && !m_cache[8][8];
    @(negedge clk); crc = 1; wdata = ref_v;
    @(negedge clk); crc = 0;
    wait_idle(n);
    if (en) begin
      chk("R7 crc busy cycles", n, 8);
      chk("R7 crc result", {30'b0, done, pass}, {30'b0, 1'b1, ref_v == m_crc()});
    end else begin
      chk("R8 disabled crc no busy", n, 0);
      chk("R8 disabled crc fail", {30'b0, done, pass}, 32'h2);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    if (!finished) $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) begin m_arr[i] = 0; m_cache[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R6 reset state
    chk("R6 status", {28'b0, busy, done, pass, err}, 32'h0);
    chk_pol("R6 restrictive policy");
    rd_chk(0, "R6 cache zero");
    // R8 before any load
    do_crc(32'h0);
    // R1/R2 writes hidden until load, OR accumulation
    wr(3, 32'h0000_00F0);
    rd_chk(3, "R1 not visible before load");
    do_load();
    rd_chk(3, "R1 visible after load");
    wr(3, 32'h0000_000F);
    wr(3, 32'h0000_0000);
    do_load();
    rd_chk(3, "R2 OR accumulate");
    wr(12, 32'hFFFF_FFFF);
    rd_chk(12, "R3 unmapped write ignored");
    // R3 row lock
    wr(8, 32'h0000_0008);
    wr(3, 32'hFFFF_0000);
    do_load();
    rd_chk(3, "R3 locked row unchanged");
    chk("R3 sticky err", {31'b0, err}, 32'h1);
    // R9 policy groups, one bit each
    wr(8, 32'h0000_2000);
    do_load();
    chk_pol("R9 scrub single bit");
    wr(9, 32'h0000_4000);
    wr(8, 32'h0010_0000);
    do_load();
    chk_pol("R9 sig and revoke B");
    // R7 key CRC
    for (int w = 0; w < 8; w++) wr(16 + w, $urandom);
    rd_chk(16, "R1 key reads zero");
    do_crc(m_crc());
    do_load();
    rd_chk(17, "R1 key reads zero after load");
    do_crc(m_crc());
    do_crc(m_crc() ^ 32'h8000_0000);
    // R4 field locks
    wr(8, 32'h0000_0200);
    wr(16, 32'hFFFF_FFFF);
    do_load();
    do_crc(m_crc());
    wr(24, 32'h0000_1111);
    wr(8, 32'h0000_0400);
    wr(24, 32'h2222_0000);
    do_load();
    rd_chk(24, "R4 hash A locked");
    wr(36, 32'h0000_0001);
    do_load();
    rd_chk(36, "R4 hash B open");
    // R10 load wins over crc; commands during busy ignored
    @(negedge clk); load = 1; crc = 1; wdata = 0;
    @(negedge clk); load = 0; crc = 0;
    wait_idle(n);
    chk("R10 load priority busy len", n, LOAD_CYC);
    chk("R10 load priority pass", {31'b0, pass}, 32'h1);
    @(negedge clk); load = 1;
    @(negedge clk); load = 0; crc = 1;
    @(negedge clk); crc = 0;
    wait_idle(n);
    chk("R10 done after load", {31'b0, done}, 32'h1);
    @(negedge clk);
    chk("R10 crc during busy dropped", {30'b0, busy, done}, 32'h0);
    // R8 key-check disable fuse, seen only after reload
    wr(8, 32'h0000_0100);
    do_crc(m_crc());
    do_load();
    do_crc(m_crc());
    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      int a  = $urandom % 64;
      if (op < 5)       wr(a, $urandom & $urandom & $urandom & $urandom);
      else if (op == 5) do_load();
      else if (op == 6) do_crc(($urandom % 2) ? m_crc() : ~m_crc());
      else begin
        rd_chk(a, "R1 random read");
        chk_pol("R9 random policy");
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule